// File: doc/BRIEF.md
# Dual-Channel Dead-Time Interlock Controller

This block is the digital control core of a two-channel half-bridge gate driver. Two logic requests, one per channel, pass through a glitch filter and then through an interlock. The interlock turns each request into a registered gate-enable. Off edges take effect at once. An on edge waits until the opposite gate has been low for a programmed number of clock cycles. When both requests are high, both gates are blanked. A bypass mode turns the interlock off, so each gate simply follows its own request and the two gates may overlap.

Above the interlock sits a gating layer. A disable input, a power-good flag for each of the three supply domains, and a start-up timer for each domain can each force both gates low. The gates start to follow the requests only after the input domain has been good for `START_IN` cycles and each output domain has been good for `START_OUT` cycles. All timings are counted in clock cycles. Each dead-time unit is one clock, so at a 100 MHz clock one unit is 10 ns.

Top module: `hb_interlock`

## Requirements
- R1: While `rst_n` is low at a clock edge, both gates are low after that edge, and all filter, dead-time and start-up state is cleared.
- R2: A gate can go high only after `pg_in` has been high for `START_IN` consecutive edges and `pg_a` and `pg_b` have each been high for `START_OUT` consecutive edges. With the other conditions met, the first gate rises on edge `START_OUT+1` after the output flags rise.
- R3: If any of `pg_in`, `pg_a` or `pg_b` is low at an edge, both gates are low after that edge, even if a timer is running. The start-up delay of that domain then restarts from zero.
- R4: A high `dis` at an edge forces both gates low after that edge. Once `dis` is low again, the gates follow the requests on the next edge, with no start-up delay.
- R5: A change on `in_a` or `in_b` is accepted only after it has been held for `FILT_LEN` consecutive edges. A pulse that is shorter than that never reaches the gate.
- R6: With `dt_mode` = 0, each gate equals its own filtered request one edge later. Both gates may be high together, and no gap is inserted.
- R7: With `dt_mode` = 1 and both filtered requests high, both gates are low after the next edge.
- R8: With `dt_mode` = 1, a gate rises only after the other gate has been low for max(D,1) full cycles, where D is the latched dead-time count.
- R9: A gate falls on the edge right after its filtered request falls, with no added delay, in either mode.
- R10: `dt_set` is latched only on edges where both gates and both filtered requests are low. A value written during activity takes effect only after the next fully idle edge.
- R11: A change at an input reaches the gate `FILT_LEN+1` edges later: `FILT_LEN` edges in the filter and one in the gate register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_a | input | 1 | Request for gate A (high side); low when unconnected |
| in_b | input | 1 | Request for gate B (low side); low when unconnected |
| dis | input | 1 | High forces both gates low; low or unconnected means run |
| dt_mode | input | 1 | 1 = interlock with dead time, 0 = bypass (overlap allowed) |
| dt_set | input | DT_W | Dead-time count in clock cycles, latched when idle |
| pg_in | input | 1 | Power-good of the input domain |
| pg_a | input | 1 | Power-good of output domain A |
| pg_b | input | 1 | Power-good of output domain B |
| gate_a | output | 1 | Gate enable A |
| gate_b | output | 1 | Gate enable B |

## Verification
Two functions can act on the same edge: the dead-time wait on a rising gate, and an override from `dis` or from a dropped power-good flag. Random segments pulse `dis` while a handoff between channels is still counting its gap. A directed step drops one power-good flag while a gate is high. A cycle model in the bench must then show both gates low on the very next edge, whatever the count had reached, and the interlock must not let the waiting gate rise early once the override is released. The same model also judges edges where the blanking of both gates coincides with a change of the latched dead time.

// File: rtl/hbi_pkg.sv
package hbi_pkg;

  // Saturating increment on a wide scratch value.
  function automatic logic [31:0] sat_next(input logic [31:0] v, input logic [31:0] cap);
    return (v >= cap) ? cap : v + 32'd1;
  endfunction

  // True once the opposite gate has been low for at least span cycles,
  // counting the current one; a zero span still needs one low cycle.
  function automatic logic gap_met(input logic [31:0] low_incl, input logic [31:0] span);
    return (low_incl != 32'd0) && (low_incl >= span);
  endfunction

  typedef logic [1:0] chan_vec_t;

endpackage

// File: rtl/hbi_glitch_filter.sv
module hbi_glitch_filter #(
  parameter int LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int CW = $clog2(LEN + 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      filt  <= 1'b0;
      run_q <= '0;
    end else if (raw == filt) begin
      run_q <= '0;
    end else if (run_q == CW'(LEN - 1)) begin
      filt  <= raw;
      run_q <= '0;
    end else begin
      run_q <= run_q + 1'b1;
    end
  end
endmodule

// File: rtl/hbi_startup_timer.sv
module hbi_startup_timer #(
  parameter int DELAY = 850
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pg,
  output logic ready
);
  localparam int TW = $clog2(DELAY + 1);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready <= 1'b0;
      cnt_q <= '0;
    end else begin
      ready <= pg && (ready || (cnt_q == TW'(DELAY - 1)));
      cnt_q <= (!pg || ready) ? '0 : cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/hbi_dt_channel.sv
module hbi_dt_channel
  import hbi_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            allow,
  input  logic            dt_mode,
  input  logic            req,
  input  logic            req_other,
  input  logic            gate_other,
  input  logic [DT_W-1:0] span,
  output logic            gate,
  output logic            rise_ok
);
  localparam logic [31:0] RUN_CAP = (32'd1 << DT_W) - 32'd1;

  logic [DT_W-1:0] low_run_q;
  logic [31:0]     low_incl;
  logic            gate_d;

  always_comb begin
    low_incl = gate_other ? 32'd0 : 32'(low_run_q) + 32'd1;
    rise_ok  = gap_met(low_incl, 32'(span));
  end

  always_comb begin
    if (!allow)        gate_d = 1'b0;
    else if (!dt_mode) gate_d = req;
    else               gate_d = req && !req_other && (gate || rise_ok);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gate      <= 1'b0;
      low_run_q <= '0;
    end else begin
      gate      <= gate_d;
      low_run_q <= gate_other ? '0 : DT_W'(sat_next(32'(low_run_q), RUN_CAP));
    end
  end
endmodule

// File: rtl/hb_interlock.sv
module hb_interlock
  import hbi_pkg::*;
#(
  parameter int FILT_LEN  = 2,
  parameter int DT_W      = 8,
  parameter int START_IN  = 850,
  parameter int START_OUT = 1800
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_a,
  input  logic            in_b,
  input  logic            dis,
  input  logic            dt_mode,
  input  logic [DT_W-1:0] dt_set,
  input  logic            pg_in,
  input  logic            pg_a,
  input  logic            pg_b,
  output logic            gate_a,
  output logic            gate_b
);
  localparam int NDOM = 3;

  chan_vec_t        raw_v, filt_v, gate_v, rise_ok_v;
  logic [NDOM-1:0]  pg_v, rdy_v;
  logic [DT_W-1:0]  dt_lat;
  logic             allow, idle, ready_all;
  logic             filt_a_w, filt_b_w, rise_ok_a_w, rise_ok_b_w;

  assign raw_v = {in_b, in_a};
  assign pg_v  = {pg_b, pg_a, pg_in};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    hbi_glitch_filter #(.LEN(FILT_LEN)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_v[g]),
      .filt (filt_v[g])
    );
  end

  for (genvar d = 0; d < NDOM; d++) begin : g_start
    localparam int DLY = (d == 0) ? START_IN : START_OUT;
    hbi_startup_timer #(.DELAY(DLY)) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .pg   (pg_v[d]),
      .ready(rdy_v[d])
    );
  end

  assign ready_all = &rdy_v;
  // Power flags act directly so that a loss overrides on the next edge.
  assign allow = !dis && (&pg_v) && ready_all;
  assign idle  = (gate_v == 2'b00) && (filt_v == 2'b00);

  always_ff @(posedge clk) begin
    if (!rst_n)    dt_lat <= '0;
    else if (idle) dt_lat <= dt_set;
  end

  for (genvar g = 0; g < 2; g++) begin : g_chan
    hbi_dt_channel #(.DT_W(DT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .allow     (allow),
      .dt_mode   (dt_mode),
      .req       (filt_v[g]),
      .req_other (filt_v[1-g]),
      .gate_other(gate_v[1-g]),
      .span      (dt_lat),
      .gate      (gate_v[g]),
      .rise_ok   (rise_ok_v[g])
    );
  end

  assign gate_a      = gate_v[0];
  assign gate_b      = gate_v[1];
  assign filt_a_w    = filt_v[0];
  assign filt_b_w    = filt_v[1];
  assign rise_ok_a_w = rise_ok_v[0];
  assign rise_ok_b_w = rise_ok_v[1];
endmodule

// File: rtl/hbi_checker.sv
module hbi_checker (
  input logic clk,
  input logic rst_n,
  input logic dis,
  input logic dt_mode,
  input logic pg_in,
  input logic pg_a,
  input logic pg_b,
  input logic filt_a,
  input logic filt_b,
  input logic rise_ok_a,
  input logic rise_ok_b,
  input logic ready_all,
  input logic gate_a,
  input logic gate_b
);
  a_r1_reset_low: assert property (@(posedge clk)
    !rst_n |=> (!gate_a && !gate_b));

  a_r2_drive_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_a || gate_b) |-> $past(ready_all));

  a_r3_power_loss_low: assert property (@(posedge clk) disable iff (!rst_n)
    !(pg_in && pg_a && pg_b) |=> (!gate_a && !gate_b));

  a_r4_disable_low: assert property (@(posedge clk) disable iff (!rst_n)
    dis |=> (!gate_a && !gate_b));

  a_r7_conflict_blank: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_mode && filt_a && filt_b) |=> (!gate_a && !gate_b));

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dt_mode) |-> !(gate_a && gate_b));

  a_r8_rise_a_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_a) && $past(dt_mode)) |-> ($past(rise_ok_a) && !$past(gate_b)));

  a_r8_rise_b_after_gap: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(gate_b) && $past(dt_mode)) |-> ($past(rise_ok_b) && !$past(gate_a)));

  a_r9_fall_a_next: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_a && !filt_a) |=> !gate_a);

  a_r9_fall_b_next: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_b && !filt_b) |=> !gate_b);
endmodule

bind hb_interlock hbi_checker i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dis      (dis),
  .dt_mode  (dt_mode),
  .pg_in    (pg_in),
  .pg_a     (pg_a),
  .pg_b     (pg_b),
  .filt_a   (filt_a_w),
  .filt_b   (filt_b_w),
  .rise_ok_a(rise_ok_a_w),
  .rise_ok_b(rise_ok_b_w),
  .ready_all(ready_all),
  .gate_a   (gate_a),
  .gate_b   (gate_b)
);

// File: tb/test_hb_interlock.sv
module test_hb_interlock;
  localparam int CLK_PERIOD = 10;
  localparam int FILT = 2;
  localparam int DTW  = 8;
  localparam int SI   = 850;
  localparam int SO   = 1800;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_a = 1'b0, in_b = 1'b0, dis = 1'b0, dt_mode = 1'b0;
  logic [DTW-1:0] dt_set = '0;
  logic pg_in = 1'b0, pg_a = 1'b0, pg_b = 1'b0;
  logic gate_a, gate_b;

  int n_checks = 0, n_fail = 0;
  string cur_req = "R1";
  bit started = 0;

  // reference model state
  bit m_f[2]; int m_frun[2]; int m_pgrun[3]; bit m_g[2]; int m_low[2]; int m_dt;
  bit t_raw[2], t_ng[2], t_rdy, t_allow, t_idle, t_pg[3];

  hb_interlock #(.FILT_LEN(FILT), .DT_W(DTW), .START_IN(SI), .START_OUT(SO)) i_hb_interlock (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .dis(dis), .dt_mode(dt_mode),
    .dt_set(dt_set), .pg_in(pg_in), .pg_a(pg_a), .pg_b(pg_b), .gate_a(gate_a), .gate_b(gate_b));

  always #(CLK_PERIOD/2) clk = ~clk;

  // Bench view of the dead-time rule: other side low for at least max(D,1) cycles.
  function automatic bit waited_enough(int low_cycles, int d);
    return low_cycles >= ((d < 1) ? 1 : d);
  endfunction

  function automatic int bump(int v, int cap);
    return (v + 1 > cap) ? cap : v + 1;
  endfunction

  always @(posedge clk) begin
    started <= 1'b1;
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin m_f[i] = 0; m_frun[i] = 0; m_g[i] = 0; m_low[i] = 0; end
      for (int i = 0; i < 3; i++) m_pgrun[i] = 0;
      m_dt = 0;
    end else begin
      t_raw[0] = in_a; t_raw[1] = in_b;
      t_pg[0] = pg_in; t_pg[1] = pg_a; t_pg[2] = pg_b;
      t_rdy   = (m_pgrun[0] >= SI) && (m_pgrun[1] >= SO) && (m_pgrun[2] >= SO);
      t_allow = !dis && pg_in && pg_a && pg_b && t_rdy;
      for (int c = 0; c < 2; c++) begin
        int lowc;
        lowc = m_g[1-c] ? 0 : m_low[c] + 1;
        if (!t_allow)      t_ng[c] = 0;
        else if (!dt_mode) t_ng[c] = m_f[c];
        else               t_ng[c] = m_f[c] && !m_f[1-c] && (m_g[c] || waited_enough(lowc, m_dt));
      end
      t_idle = !m_g[0] && !m_g[1] && !m_f[0] && !m_f[1];
      if (t_idle) m_dt = int'(dt_set);
      for (int c = 0; c < 2; c++) m_low[c] = m_g[1-c] ? 0 : bump(m_low[c], 255);
      for (int c = 0; c < 2; c++) begin
        if (t_raw[c] == m_f[c]) m_frun[c] = 0;
        else begin
          m_frun[c]++;
          if (m_frun[c] == FILT) begin m_f[c] = t_raw[c]; m_frun[c] = 0; end
        end
      end
      for (int i = 0; i < 3; i++) m_pgrun[i] = t_pg[i] ? bump(m_pgrun[i], 1000000) : 0;
      m_g[0] = t_ng[0]; m_g[1] = t_ng[1];
    end
  end

  always @(negedge clk) begin
    if (started) begin
      n_checks++;
      if (gate_a !== m_g[0] || gate_b !== m_g[1]) begin
        n_fail++;
        $display("FAIL %s model gates actual a=%b b=%b expected a=%b b=%b at %0t",
                 cur_req, gate_a, gate_b, m_g[0], m_g[1], $time);
      end
    end
  end

  task automatic expect_int(string req, int actual, int expected);
    n_checks++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic cycles(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Swap the active channel and measure fall latency and the low-low gap.
  task automatic handoff(bit to_b, int exp_gap, string req);
    int k = 0, gap = 0;
    @(negedge clk); in_a = !to_b; in_b = to_b;
    while (((to_b ? gate_a : gate_b) === 1'b1) && k < 50) begin @(negedge clk); k++; end
    expect_int("R11 fall latency", k, FILT + 1);
    while (((to_b ? gate_b : gate_a) !== 1'b1) && gap < 300) begin @(negedge clk); gap++; end
    expect_int(req, gap, exp_gap);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired actual running expected finished");
    finish_run();
  end

  initial begin
    int n;
    bit seen;
    void'($urandom(32'd4242));
    // R1: reset state
    cur_req = "R1";
    cycles(3);
    expect_int("R1 gate_a in reset", int'(gate_a), 0);
    expect_int("R1 gate_b in reset", int'(gate_b), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2: start-up delay before the first rise
    cur_req = "R2";
    @(negedge clk); pg_in = 1; pg_a = 1; pg_b = 1; in_a = 1; dt_mode = 1; dt_set = 8'd4;
    n = 0;
    while (gate_a !== 1'b1 && n < SO + 20) begin @(negedge clk); n++; end
    expect_int("R2 cycles to first rise", n, SO + 1);

    // R8 / R9 / R11: handoff with D=4
    cur_req = "R8";
    handoff(1'b1, 4, "R8 gap D=4");

    // R10: value written while busy is not used until idle
    cur_req = "R10";
    @(negedge clk); dt_set = 8'd10;
    handoff(1'b0, 4, "R10 old dead time kept");
    @(negedge clk); in_a = 0; in_b = 0;
    cycles(6);
    in_a = 1;
    cycles(6);
    handoff(1'b1, 10, "R10 new dead time after idle");
    @(negedge clk); dt_set = 8'd0; in_b = 0;
    cycles(6);
    in_a = 1;
    cycles(6);
    handoff(1'b1, 1, "R8 zero count still one cycle");

    // R7: conflict blanks both
    cur_req = "R7";
    @(negedge clk); in_a = 1; in_b = 1;
    cycles(6);
    expect_int("R7 both blanked", int'(gate_a) + int'(gate_b), 0);

    // R6: bypass lets both follow and overlap
    cur_req = "R6";
    @(negedge clk); dt_mode = 0;
    cycles(3);
    expect_int("R6 overlap allowed", int'(gate_a) + int'(gate_b), 2);

    // R5: narrow pulse suppressed, pulse of FILT cycles passed
    cur_req = "R5";
    @(negedge clk); in_a = 0; in_b = 0;
    cycles(6);
    in_a = 1; @(negedge clk); in_a = 0;
    seen = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (gate_a === 1'b1) seen = 1; end
    expect_int("R5 short pulse dropped", int'(seen), 0);
    in_a = 1; cycles(FILT); in_a = 0;
    seen = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (gate_a === 1'b1) seen = 1; end
    expect_int("R5 long pulse passed", int'(seen), 1);

    // R4: disable overrides at once and releases with no delay
    cur_req = "R4";
    in_a = 1; cycles(5);
    dis = 1; @(negedge clk);
    expect_int("R4 disable low next edge", int'(gate_a), 0);
    dis = 0; @(negedge clk);
    expect_int("R4 release resumes next edge", int'(gate_a), 1);

    // R3: supply loss overrides and restarts the delay
    cur_req = "R3";
    @(negedge clk); pg_b = 0; @(negedge clk);
    expect_int("R3 low after power loss", int'(gate_a), 0);
    pg_b = 1;
    n = 0;
    while (gate_a !== 1'b1 && n < SO + 20) begin @(negedge clk); n++; end
    expect_int("R3 restart delay", n, SO + 1);

    // Random mix of handoffs, conflicts, mode and disable, judged by the model
    cur_req = "R8 random";
    dt_mode = 1;
    for (int s = 0; s < 3000; s++) begin
      @(negedge clk);
      in_a = $urandom_range(0, 1);
      in_b = $urandom_range(0, 1);
      if ($urandom_range(0, 15) == 0) dt_mode = ~dt_mode;
      if ($urandom_range(0, 3) == 0) dt_set = DTW'($urandom_range(0, 12));
      dis = ($urandom_range(0, 15) == 0);
      cycles($urandom_range(0, 5));
    end
    dis = 0;
    cycles(10);
    finish_run();
  end
endmodule